// File: doc/BRIEF.md
# Segment LCD command decoder and display RAM loader

This block sits behind a two-wire bus slave that has already recovered bytes and framing. It receives a start pulse, a stop pulse and a byte strobe with its byte. It separates each transfer into a run of command bytes followed by display data bytes. Commands set the drive mode, display enable, power-saving and bias bits, the blink setting, the RAM bank selection, the RAM column pointer and a software subaddress counter. Data bytes are spread over a 24-column by 4-row display RAM according to the drive mode. A read port lets the backplane scanner fetch one column of four row bits at a time.

Writes happen only when the software subaddress counter equals the strapped hardware subaddress. The column pointer advances whether or not a write happens, and it carries into the subaddress counter when it passes the last column. This lets several chips on one bus take consecutive slices of a single data stream. While a data byte is being spread over its columns, the block raises a hold request so that the bus side stretches the clock.

The sequencer has four states. ST_IDLE is outside a transfer. ST_CMD takes command bytes. ST_DATA waits for a data byte. ST_STORE writes one column per cycle. A start moves any state to ST_CMD, and a stop moves ST_CMD or ST_DATA to ST_IDLE. A command byte with bit 7 clear moves ST_CMD to ST_DATA. A data byte moves ST_DATA to ST_STORE. The last column of a byte moves ST_STORE back to ST_DATA.

Top module: `seglcd_cmd_loader`

## Requirements
- R1: After reset the drive mode is 1:4 (code 00). Blink is off, with frequency 0 and normal type. Display enable, power saving, bias, both bank bits, the pointer, the subaddress counter, every RAM bit and hold_req are 0.
- R2: Bit 7 of a command byte set means the next byte is a command. Bit 7 clear means every further byte up to stop is data. A start always returns to command decoding, even in the middle of data.
- R3: Mode-set is the low-7-bit pattern 10xxxxx. Bit 4 sets power saving, bit 3 display enable, bit 2 bias, and bits 1:0 the drive mode (00 = 1:4, 01 = static, 10 = 1:2, 11 = 1:3). Status bits change only in the cycle after a byte strobe.
- R4: Load-pointer is 0xxxxxx. Bits 4:0 become the RAM column pointer.
- R5: Device-select is 1100xxx. Bits 2:0 load the subaddress counter. A column is written only while the counter equals hw_subaddr.
- R6: On a subaddress mismatch the column is not written, but the pointer advances exactly as for a write.
- R7: A column step from column 23 or above sets the pointer to 0 and increments the 3-bit subaddress counter, which wraps from 7 to 0.
- R8: Data bits are taken MSB first and fill rows from row 0 up within each column. Static mode writes 1 bit into each of 8 columns. 1:2 writes 2 bits into each of 4 columns. 1:4 writes 4 bits into each of 2 columns. 1:3 writes 3, 3 and 2 bits into 3 columns, and row 2 of the third column is left unchanged.
- R9: Bank-select is 1111xxx, with bit 1 the input bank and bit 0 the output bank. In static and 1:2 modes, input bank 1 moves writes to rows 2 and up. In 1:3 and 1:4 modes the input bank is ignored.
- R10: Blink is 1110xxx. Bit 2 selects alternate-bank blinking, and bits 1:0 set the blink frequency.
- R11: hold_req is high for exactly as many cycles as the byte occupies columns: 8, 4, 3 or 2 for static, 1:2, 1:3 or 1:4.
- R12: Pattern 1101xxx is ignored, but its bit 7 still decides whether commands continue. Bytes outside a transfer are ignored. A stop keeps the pointer and the subaddress counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | One-cycle start-condition pulse |
| rx_stop | input | 1 | One-cycle stop-condition pulse |
| rx_valid | input | 1 | Byte strobe |
| rx_byte | input | 8 | Received byte |
| hw_subaddr | input | 3 | Strapped hardware subaddress |
| hold_req | output | 1 | Clock-stretch request while storing |
| rd_col | input | 5 | Scanner read column |
| rd_rows | output | 4 | Row bits of the read column, bit r = row r |
| drive_mode | output | 2 | Drive mode code |
| disp_en | output | 1 | Display enable |
| low_power | output | 1 | Power-saving mode |
| bias_sel | output | 1 | Bias select |
| blink_freq | output | 2 | Blink frequency, 0 = off |
| blink_alt | output | 1 | Alternate-bank blink type |
| in_bank | output | 1 | Input bank select |
| out_bank | output | 1 | Output bank select |
| data_ptr | output | 5 | RAM column pointer |
| sub_cnt | output | 3 | Software subaddress counter |

## Verification
The assertions assume that the bus side never presents a byte, a start or a stop while hold_req is high. They also assume that start, stop and a byte never share a cycle. Under these assumptions the pointer steps once per storing cycle, and status bits move only after a byte strobe. The bench keeps within these limits. It sends every byte through one task, which waits for hold_req to fall before it returns, and it pulses start and stop only between bytes.

// File: rtl/seglcd_pkg.sv
package seglcd_pkg;

    typedef enum logic [1:0] {
        DM_MUX4   = 2'b00,
        DM_STATIC = 2'b01,
        DM_MUX2   = 2'b10,
        DM_MUX3   = 2'b11
    } drive_mode_e;

    typedef enum logic [2:0] {
        OP_MODE,
        OP_PTR,
        OP_DEVSEL,
        OP_BANK,
        OP_BLINK,
        OP_NONE
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_STORE
    } seq_state_e;

    function automatic cmd_op_e decode_op(input logic [6:0] b);
        if (!b[6])
            return OP_PTR;
        else if (!b[5])
            return OP_MODE;
        else if (b[4:3] == 2'b00)
            return OP_DEVSEL;
        else if (b[4:3] == 2'b11)
            return OP_BANK;
        else if (b[4:3] == 2'b10)
            return OP_BLINK;
        else
            return OP_NONE;
    endfunction

    function automatic logic [3:0] bits_per_col(input drive_mode_e m);
        unique case (m)
            DM_STATIC: return 4'd1;
            DM_MUX2:   return 4'd2;
            DM_MUX3:   return 4'd3;
            default:   return 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/seglcd_status_regs.sv
module seglcd_status_regs
    import seglcd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_stb,
    input  logic [7:0]  cmd_byte,
    output drive_mode_e drive_mode,
    output logic        disp_en,
    output logic        low_power,
    output logic        bias_sel,
    output logic [1:0]  blink_freq,
    output logic        blink_alt,
    output logic        in_bank,
    output logic        out_bank
);

    cmd_op_e op;
    assign op = decode_op(cmd_byte[6:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_mode <= DM_MUX4;
            disp_en    <= 1'b0;
            low_power  <= 1'b0;
            bias_sel   <= 1'b0;
            blink_freq <= 2'b00;
            blink_alt  <= 1'b0;
            in_bank    <= 1'b0;
            out_bank   <= 1'b0;
        end else if (cmd_stb) begin
            unique case (op)
                OP_MODE: begin
                    low_power  <= cmd_byte[4];
                    disp_en    <= cmd_byte[3];
                    bias_sel   <= cmd_byte[2];
                    drive_mode <= drive_mode_e'(cmd_byte[1:0]);
                end
                OP_BLINK: begin
                    blink_alt  <= cmd_byte[2];
                    blink_freq <= cmd_byte[1:0];
                end
                OP_BANK: begin
                    in_bank  <= cmd_byte[1];
                    out_bank <= cmd_byte[0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/seglcd_store_seq.sv
module seglcd_store_seq
    import seglcd_pkg::*;
#(
    parameter int COLS   = 24,
    parameter int ROWS   = 4,
    parameter int BYTE_W = 8,
    parameter int PTR_W  = 5,
    parameter int SUB_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              rx_stop,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [SUB_W-1:0]  hw_subaddr,
    input  drive_mode_e       drive_mode,
    input  logic              in_bank,
    output logic              cmd_stb,
    output logic              hold_req,
    output logic [PTR_W-1:0]  data_ptr,
    output logic [SUB_W-1:0]  sub_cnt,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_col,
    output logic [ROWS-1:0]   wr_mask,
    output logic [ROWS-1:0]   wr_bits
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [PTR_W-1:0] LAST_COL = PTR_W'(COLS - 1);

    seq_state_e        state, nstate;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bits_left;
    logic [CNT_W-1:0]  bpc, take;
    logic              last_col, bank_ok, data_stb;
    int                base;
    cmd_op_e           op;

    assign op       = decode_op(rx_byte[6:0]);
    assign bpc      = CNT_W'(bits_per_col(drive_mode));
    assign take     = (bits_left < bpc) ? bits_left : bpc;
    assign last_col = (bits_left <= bpc);
    assign bank_ok  = (drive_mode == DM_STATIC) || (drive_mode == DM_MUX2);
    assign base     = (bank_ok && in_bank) ? 2 : 0;
    assign data_stb = (state == ST_DATA) && rx_valid && !rx_start && !rx_stop;

    // next-state process
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (rx_start) nstate = ST_CMD;
            ST_CMD: begin
                if (rx_start)                    nstate = ST_CMD;
                else if (rx_stop)                nstate = ST_IDLE;
                else if (rx_valid && !rx_byte[7]) nstate = ST_DATA;
            end
            ST_DATA: begin
                if (rx_start)      nstate = ST_CMD;
                else if (rx_stop)  nstate = ST_IDLE;
                else if (rx_valid) nstate = ST_STORE;
            end
            ST_STORE: begin
                if (rx_start)      nstate = ST_CMD;
                else if (last_col) nstate = ST_DATA;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // output process
    always_comb begin
        cmd_stb  = (state == ST_CMD) && rx_valid && !rx_start && !rx_stop;
        hold_req = (state == ST_STORE);
        wr_en    = (state == ST_STORE) && (sub_cnt == hw_subaddr);
        wr_col   = data_ptr;
        wr_mask  = '0;
        wr_bits  = '0;
        for (int k = 0; k < ROWS; k++) begin
            if ((k < int'(take)) && (base + k < ROWS)) begin
                wr_mask[base + k] = 1'b1;
                wr_bits[base + k] = shreg[BYTE_W - 1 - k];
            end
        end
    end

    // pointer, subaddress counter and byte shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_ptr  <= '0;
            sub_cnt   <= '0;
            shreg     <= '0;
            bits_left <= '0;
        end else begin
            if (cmd_stb && op == OP_PTR) begin
                data_ptr <= rx_byte[PTR_W-1:0];
            end else if (cmd_stb && op == OP_DEVSEL) begin
                sub_cnt <= rx_byte[SUB_W-1:0];
            end else if (state == ST_STORE && !rx_start) begin
                if (data_ptr >= LAST_COL) begin
                    data_ptr <= '0;
                    sub_cnt  <= sub_cnt + 1'b1;
                end else begin
                    data_ptr <= data_ptr + 1'b1;
                end
            end
            if (data_stb) begin
                shreg     <= rx_byte;
                bits_left <= CNT_W'(BYTE_W);
            end else if (state == ST_STORE) begin
                shreg     <= shreg << take;
                bits_left <= bits_left - take;
            end
        end
    end

endmodule

// File: rtl/seglcd_disp_ram.sv
module seglcd_disp_ram #(
    parameter int COLS  = 24,
    parameter int ROWS  = 4,
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_col,
    input  logic [ROWS-1:0]  wr_mask,
    input  logic [ROWS-1:0]  wr_bits,
    input  logic [PTR_W-1:0] rd_col,
    output logic [ROWS-1:0]  rd_rows
);

    logic [ROWS-1:0] mem [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_col
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[c] <= '0;
            else if (wr_en && wr_col == PTR_W'(c))
                mem[c] <= (mem[c] & ~wr_mask) | (wr_bits & wr_mask);
        end
    end

    always_comb begin
        rd_rows = '0;
        for (int c = 0; c < COLS; c++)
            if (rd_col == PTR_W'(c)) rd_rows = mem[c];
    end

endmodule

// File: rtl/seglcd_cmd_loader.sv
module seglcd_cmd_loader
    import seglcd_pkg::*;
#(
    parameter int COLS   = 24,
    parameter int ROWS   = 4,
    parameter int BYTE_W = 8,
    parameter int PTR_W  = 5,
    parameter int SUB_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              rx_stop,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [SUB_W-1:0]  hw_subaddr,
    output logic              hold_req,
    input  logic [PTR_W-1:0]  rd_col,
    output logic [ROWS-1:0]   rd_rows,
    output logic [1:0]        drive_mode,
    output logic              disp_en,
    output logic              low_power,
    output logic              bias_sel,
    output logic [1:0]        blink_freq,
    output logic              blink_alt,
    output logic              in_bank,
    output logic              out_bank,
    output logic [PTR_W-1:0]  data_ptr,
    output logic [SUB_W-1:0]  sub_cnt
);

    drive_mode_e      mode_q;
    logic             cmd_stb, wr_en;
    logic [PTR_W-1:0] wr_col;
    logic [ROWS-1:0]  wr_mask, wr_bits;

    assign drive_mode = mode_q;

    seglcd_status_regs u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_stb    (cmd_stb),
        .cmd_byte   (rx_byte),
        .drive_mode (mode_q),
        .disp_en    (disp_en),
        .low_power  (low_power),
        .bias_sel   (bias_sel),
        .blink_freq (blink_freq),
        .blink_alt  (blink_alt),
        .in_bank    (in_bank),
        .out_bank   (out_bank)
    );

    seglcd_store_seq #(
        .COLS(COLS), .ROWS(ROWS), .BYTE_W(BYTE_W), .PTR_W(PTR_W), .SUB_W(SUB_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_start   (rx_start),
        .rx_stop    (rx_stop),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .hw_subaddr (hw_subaddr),
        .drive_mode (mode_q),
        .in_bank    (in_bank),
        .cmd_stb    (cmd_stb),
        .hold_req   (hold_req),
        .data_ptr   (data_ptr),
        .sub_cnt    (sub_cnt),
        .wr_en      (wr_en),
        .wr_col     (wr_col),
        .wr_mask    (wr_mask),
        .wr_bits    (wr_bits)
    );

    seglcd_disp_ram #(
        .COLS(COLS), .ROWS(ROWS), .PTR_W(PTR_W)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_col  (wr_col),
        .wr_mask (wr_mask),
        .wr_bits (wr_bits),
        .rd_col  (rd_col),
        .rd_rows (rd_rows)
    );

endmodule

// File: rtl/seglcd_loader_chk.sv
module seglcd_loader_chk #(
    parameter int COLS  = 24,
    parameter int PTR_W = 5,
    parameter int SUB_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_start,
    input logic             rx_stop,
    input logic             rx_valid,
    input logic             hold_req,
    input logic [PTR_W-1:0] data_ptr,
    input logic [SUB_W-1:0] sub_cnt,
    input logic [1:0]       drive_mode,
    input logic             disp_en,
    input logic             low_power,
    input logic             bias_sel,
    input logic [1:0]       blink_freq,
    input logic             blink_alt,
    input logic             in_bank,
    input logic             out_bank
);

    localparam logic [PTR_W-1:0] LAST_COL = PTR_W'(COLS - 1);

    logic [9:0] status_vec;
    assign status_vec = {drive_mode, disp_en, low_power, bias_sel,
                         blink_freq, blink_alt, in_bank, out_bank};

    // R11: input assumption, nothing arrives while storage is pending
    a_r11_quiet_while_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |-> (!rx_valid && !rx_start && !rx_stop));

    // R6: the pointer steps once per storing cycle, written or not
    a_r6_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> (data_ptr == (($past(data_ptr) >= LAST_COL) ? '0
                                   : PTR_W'($past(data_ptr) + 1'b1))));

    // R7: stepping past the last column carries into the subaddress counter
    a_r7_sub_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req && data_ptr >= LAST_COL) |=> (sub_cnt == SUB_W'($past(sub_cnt) + 1'b1)));

    a_r7_sub_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req && data_ptr < LAST_COL) |=> $stable(sub_cnt));

    // R3: status bits move only after a byte strobe
    a_r3_status_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_vec) |-> $past(rx_valid));

    // R12: with no byte and no storage the pointer holds
    a_r12_ptr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_req && !rx_valid) |=> $stable(data_ptr));

endmodule

bind seglcd_cmd_loader seglcd_loader_chk #(
    .COLS(COLS), .PTR_W(PTR_W), .SUB_W(SUB_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_start   (rx_start),
    .rx_stop    (rx_stop),
    .rx_valid   (rx_valid),
    .hold_req   (hold_req),
    .data_ptr   (data_ptr),
    .sub_cnt    (sub_cnt),
    .drive_mode (drive_mode),
    .disp_en    (disp_en),
    .low_power  (low_power),
    .bias_sel   (bias_sel),
    .blink_freq (blink_freq),
    .blink_alt  (blink_alt),
    .in_bank    (in_bank),
    .out_bank   (out_bank)
);

// File: tb/seglcd_cmd_loader_tb.sv
`timescale 1ns/1ps
module seglcd_cmd_loader_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_start = 1'b0, rx_stop = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [2:0] hw_subaddr = 3'd0;
    logic       hold_req;
    logic [4:0] rd_col = '0;
    logic [3:0] rd_rows;
    logic [1:0] drive_mode, blink_freq;
    logic       disp_en, low_power, bias_sel, blink_alt, in_bank, out_bank;
    logic [4:0] data_ptr;
    logic [2:0] sub_cnt;

    int errors = 0;
    int checks = 0;
    int hcnt   = 0;

    always #2 clk = ~clk;

    seglcd_cmd_loader dut_i (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_stop(rx_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .hw_subaddr(hw_subaddr),
        .hold_req(hold_req), .rd_col(rd_col), .rd_rows(rd_rows),
        .drive_mode(drive_mode), .disp_en(disp_en), .low_power(low_power),
        .bias_sel(bias_sel), .blink_freq(blink_freq), .blink_alt(blink_alt),
        .in_bank(in_bank), .out_bank(out_bank), .data_ptr(data_ptr),
        .sub_cnt(sub_cnt)
    );

    // {mode, ptr, data, check col, expected rows, expected ptr, expected hold}
    localparam int NV = 5;
    localparam logic [32:0] VEC [NV] = '{
        {2'b01, 5'd0,  8'hA5, 5'd2,  4'b0001, 5'd8,  4'd8},
        {2'b10, 5'd8,  8'hD2, 5'd9,  4'b0010, 5'd12, 4'd4},
        {2'b00, 5'd12, 8'h69, 5'd13, 4'b1001, 5'd14, 4'd2},
        {2'b11, 5'd14, 8'hB7, 5'd16, 4'b0011, 5'd17, 4'd3},
        {2'b00, 5'd22, 8'hFF, 5'd23, 4'b1111, 5'd0,  4'd2}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); rx_stop = 1'b1;
        @(negedge clk); rx_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_byte = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        hcnt = 0;
        while (hold_req) begin
            hcnt++;
            @(negedge clk);
        end
    endtask

    task automatic col_is(input string tag, input logic [4:0] c, input logic [3:0] exp);
        rd_col = c;
        #1;
        check(tag, int'(rd_rows), int'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 mode", drive_mode, 0);
        check("R1 blink", {blink_alt, blink_freq}, 0);
        check("R1 flags", {disp_en, low_power, bias_sel, in_bank, out_bank}, 0);
        check("R1 ptr/sub", {data_ptr, sub_cnt}, 0);
        check("R1 hold", hold_req, 0);
        col_is("R1 ram", 5'd7, 4'b0000);

        // R8 R11 table of packing per mode
        for (int i = 0; i < NV; i++) begin
            pulse_start();
            send(8'hC8 | {6'd0, VEC[i][32:31]});
            send(8'hE0);
            send({3'b000, VEC[i][30:26]});
            send(VEC[i][25:18]);
            check("R11 hold cycles", hcnt, int'(VEC[i][3:0]));
            pulse_stop();
            col_is("R8 packing", VEC[i][17:13], VEC[i][12:9]);
            check("R8 ptr after byte", data_ptr, int'(VEC[i][8:4]));
        end
        check("R7 wrap carry", sub_cnt, 1);
        col_is("R8 1:3 first col", 5'd14, 4'b0101);

        // R5 R6 mismatch: no write, pointer still moves
        pulse_start();
        send(8'hC8); send(8'hE3); send(8'h05); send(8'hFF);
        pulse_stop();
        col_is("R5 gated col5", 5'd5, 4'b0001);
        col_is("R6 gated col6", 5'd6, 4'b0000);
        check("R6 ptr", data_ptr, 7);
        check("R5 sub", sub_cnt, 3);

        // R7 subaddress wrap 7 -> 0 then write resumes
        pulse_start();
        send(8'hE7); send(8'h17); send(8'hF0);
        pulse_stop();
        col_is("R7 col23 kept", 5'd23, 4'b1111);
        col_is("R7 col0 written", 5'd0, 4'b0000);
        check("R7 ptr", data_ptr, 1);
        check("R7 sub", sub_cnt, 0);

        // R9 bank in static mode, rows 2 up
        pulse_start();
        send(8'hC9); send(8'hFB); send(8'hE0); send(8'h12); send(8'hC0);
        pulse_stop();
        col_is("R9 static bank col18", 5'd18, 4'b0100);
        col_is("R9 static bank col22", 5'd22, 4'b1011);
        check("R9 bank bits", {in_bank, out_bank}, 3);
        check("R7 ptr after static wrap", data_ptr, 2);

        // R9 bank ignored in 1:4
        pulse_start();
        send(8'hC8); send(8'hE0); send(8'h14); send(8'h80);
        pulse_stop();
        col_is("R9 1:4 ignores bank", 5'd20, 4'b0001);

        // R3 mode-set fields
        pulse_start(); send(8'hDE); pulse_stop();
        check("R3 mode", drive_mode, 2);
        check("R3 flags", {low_power, disp_en, bias_sel}, 7);

        // R10 blink fields
        pulse_start(); send(8'hF6); pulse_stop();
        check("R10 blink", {blink_alt, blink_freq}, 6);

        // R12 unknown opcode with continuation, R4 pointer load
        pulse_start(); send(8'hE8); send(8'h03); pulse_stop();
        check("R12 unknown no effect", {drive_mode, disp_en, low_power, bias_sel,
              blink_freq, blink_alt, in_bank, out_bank}, 10'b10_1_1_1_10_1_1_1);
        check("R4 ptr load", data_ptr, 3);

        // R12 unknown opcode without continuation, R2 next byte is data
        pulse_start(); send(8'h68); send(8'hC9);
        check("R2 data hold 1:2", hcnt, 4);
        pulse_stop();
        check("R2 not a command", drive_mode, 2);
        col_is("R9 1:2 bank rows", 5'd3, 4'b1100);
        check("R2 ptr", data_ptr, 7);

        // R12 byte outside a transfer, stop keeps pointer
        send(8'h0A);
        check("R12 outside ignored", data_ptr, 7);
        check("R12 outside hold", hcnt, 0);

        // R2 start in the middle of data
        pulse_start(); send(8'h01); send(8'h00);
        check("R2 ptr mid data", data_ptr, 5);
        pulse_start(); send(8'h0A);
        check("R2 restart to cmd", data_ptr, 10);
        pulse_stop();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule